// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialisation Sequencer

This block owns refresh for an EDO DRAM. After reset it waits through a long power-up pause and then issues a run of CAS-before-RAS (CBR) cycles that prime the device's internal row counter. Only after that does it raise `init_done` and let host requests through. From then on, an interval timer adds one owed refresh per period. Periodically spreading 2048 refreshes over 32 ms gives one every 15.6 us, which is 1560 cycles at 100 MHz. Owed refreshes are served as CBR cycles whenever the access controller hands over the DRAM strobes.

The bus handover uses a request/grant pair. The sequencer raises `refresh_req` and waits for `refresh_gnt`. It then drives RAS and CAS through a fixed CBR waveform with WE held high, and drops the request in the cycle that closes the refresh. The engine has five states:

- CBR_IDLE: the request follows whether any work is waiting.
- CBR_PRECH: RAS precharge.
- CBR_CASLEAD: CAS low ahead of RAS.
- CBR_RASLOW: both strobes low.
- CBR_DONE: strobes high and the request low.

Its transitions are:

- IDLE to PRECH when work is waiting and the grant is seen.
- Each timed state to the next when its phase counter reaches zero.
- DONE back to IDLE.

The init machine has three states:

- INI_PAUSE counts the pause and moves to INI_CBR.
- INI_CBR moves to INI_RUN once the last initial cycle finishes.
- INI_RUN is final.

If the owed count reaches its limit, a sticky flag is raised.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `ram_ras_n`, `ram_cas_n` and `ram_we_n` are high, and `refresh_req`, `init_done`, `host_ok` and `owed_sat` are low.
- R2: After reset is released, `refresh_req` stays low through the first PAUSE_CYC-1 rising edges and is high after edge PAUSE_CYC.
- R3: Exactly INIT_CYCLES CBR cycles complete before `init_done` rises. Once high, `init_done` stays high until reset.
- R4: Each CBR cycle has the following shape:
  - CAS is low with RAS high for exactly T_CSR cycles.
  - Both strobes are then low for exactly T_RAS cycles.
  - Both strobes rise together.
  - RAS and CAS were both high for at least T_RP cycles before CAS falls.
- R5: `ram_we_n` is high in every cycle in which RAS is low.
- R6: Strobes move only after `refresh_gnt` has been sampled high while `refresh_req` is high. While no grant comes, the request stays high and RAS stays high. `refresh_req` is high while either strobe is low, and it is low in the cycle in which RAS rises.
- R7: After `init_done` rises, one refresh becomes owed every INTERVAL_CYC cycles. The first request appears exactly INTERVAL_CYC cycles after `init_done` rises.
- R8: The owed count never exceeds OWED_MAX, and further ticks at the limit are dropped. `owed_sat` rises once the limit is reached and stays high until reset. After long starvation, exactly OWED_MAX cycles are served.
- R9: `host_ok` equals `host_req` gated by `init_done`, so host traffic is blocked until initialisation ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_gnt | input | 1 | Access controller hands the strobes to the sequencer |
| host_req | input | 1 | Host access request from the access controller |
| refresh_req | output | 1 | Sequencer wants the strobes |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | 1 | Column strobe, active low |
| ram_we_n | output | 1 | Write enable, held high |
| init_done | output | 1 | Power-up pause and initial CBR cycles finished |
| host_ok | output | 1 | Host request passed through after initialisation |
| owed_sat | output | 1 | Sticky: owed count reached its limit |

## Verification
The assertions assume that the access controller keeps `refresh_gnt` high for as long as `refresh_req` is high once it has granted, and releases it when the request drops. The bench models exactly that controller. At each falling edge it sets the grant to the request, gated by an enable flag that it uses to starve the sequencer on purpose. Parameters in the bench are shortened, with a 300-cycle pause and a 400-cycle interval. This keeps every starvation window and every served burst inside one known interval, so no timer tick lands in a counting window.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

    typedef enum logic [2:0] {
        CBR_IDLE,
        CBR_PRECH,
        CBR_CASLEAD,
        CBR_RASLOW,
        CBR_DONE
    } cbr_state_t;

    typedef enum logic [1:0] {
        INI_PAUSE,
        INI_CBR,
        INI_RUN
    } init_state_t;

endpackage

// File: rtl/refseq_interval.sv
module refseq_interval #(
    parameter int INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);
    localparam int TW = $clog2(INTERVAL_CYC + 1);

    logic [TW-1:0] count;
    logic          at_end;

    assign at_end = (count == TW'(INTERVAL_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (enable) begin
            if (at_end) begin
                count <= '0;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    assign tick = enable && at_end;

endmodule

// File: rtl/refseq_owed.sv
module refseq_owed #(
    parameter int OWED_MAX = 8,
    localparam int OW = $clog2(OWED_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add,
    input  logic          take,
    output logic [OW-1:0] owed,
    output logic          saturated
);
    logic at_max;

    assign at_max = (owed == OW'(OWED_MAX));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
        end else begin
            unique case ({add, take})
                2'b10: if (!at_max) owed <= owed + 1'b1;
                2'b01: if (owed != '0) owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saturated <= 1'b0;
        end else if (at_max) begin
            saturated <= 1'b1;
        end
    end

endmodule

// File: rtl/refseq_cbr.sv
module refseq_cbr
    import refseq_pkg::*;
#(
    parameter int T_RP  = 4,
    parameter int T_CSR = 1,
    parameter int T_RAS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic gnt,
    output logic req,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic done
);
    localparam int MAXT = (T_RP > T_CSR) ? ((T_RP > T_RAS) ? T_RP : T_RAS)
                                         : ((T_CSR > T_RAS) ? T_CSR : T_RAS);
    localparam int CW = $clog2(MAXT + 1);

    cbr_state_t    state;
    cbr_state_t    nxt;
    logic [CW-1:0] cnt;

    function automatic logic [CW-1:0] phase_len(cbr_state_t s);
        case (s)
            CBR_PRECH:   return CW'(T_RP - 1);
            CBR_CASLEAD: return CW'(T_CSR - 1);
            CBR_RASLOW:  return CW'(T_RAS - 1);
            default:     return '0;
        endcase
    endfunction

    // state register and phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CBR_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) begin
                cnt <= phase_len(nxt);
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            CBR_IDLE:    if (want && gnt) nxt = CBR_PRECH;
            CBR_PRECH:   if (cnt == '0) nxt = CBR_CASLEAD;
            CBR_CASLEAD: if (cnt == '0) nxt = CBR_RASLOW;
            CBR_RASLOW:  if (cnt == '0) nxt = CBR_DONE;
            CBR_DONE:    nxt = CBR_IDLE;
            default:     nxt = CBR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req   = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        done  = 1'b0;
        unique case (state)
            CBR_IDLE:    req = want;
            CBR_PRECH:   req = 1'b1;
            CBR_CASLEAD: begin
                req   = 1'b1;
                cas_n = 1'b0;
            end
            CBR_RASLOW:  begin
                req   = 1'b1;
                cas_n = 1'b0;
                ras_n = 1'b0;
            end
            CBR_DONE:    done = 1'b1;
            default:     req = 1'b0;
        endcase
    end

    assign we_n = 1'b1;

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import refseq_pkg::*;
#(
    parameter int PAUSE_CYC    = 20000,
    parameter int INTERVAL_CYC = 1560,
    parameter int INIT_CYCLES  = 8,
    parameter int OWED_MAX     = 8,
    parameter int T_RP         = 4,
    parameter int T_CSR        = 1,
    parameter int T_RAS        = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic refresh_gnt,
    input  logic host_req,
    output logic refresh_req,
    output logic ram_ras_n,
    output logic ram_cas_n,
    output logic ram_we_n,
    output logic init_done,
    output logic host_ok,
    output logic owed_sat
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int IW = $clog2(INIT_CYCLES + 1);
    localparam int OW = $clog2(OWED_MAX + 1);

    init_state_t   ist;
    init_state_t   ist_nxt;
    logic [PW-1:0] pause_cnt;
    logic [IW-1:0] init_left;
    logic [OW-1:0] owed_cnt;
    logic          cbr_done;
    logic          cbr_want;
    logic          tick;
    logic          run_phase;

    assign run_phase = (ist == INI_RUN);

    // init state register with its counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ist       <= INI_PAUSE;
            pause_cnt <= '0;
            init_left <= IW'(INIT_CYCLES);
        end else begin
            ist <= ist_nxt;
            if (ist == INI_PAUSE) begin
                pause_cnt <= pause_cnt + 1'b1;
            end
            if (ist == INI_CBR && cbr_done && init_left != '0) begin
                init_left <= init_left - 1'b1;
            end
        end
    end

    // init next state
    always_comb begin
        ist_nxt = ist;
        unique case (ist)
            INI_PAUSE: if (pause_cnt == PW'(PAUSE_CYC - 1)) ist_nxt = INI_CBR;
            INI_CBR:   if (init_left == '0) ist_nxt = INI_RUN;
            INI_RUN:   ist_nxt = INI_RUN;
            default:   ist_nxt = INI_PAUSE;
        endcase
    end

    // init outputs
    always_comb begin
        cbr_want  = 1'b0;
        init_done = 1'b0;
        unique case (ist)
            INI_PAUSE: cbr_want = 1'b0;
            INI_CBR:   cbr_want = (init_left != '0);
            INI_RUN:   begin
                init_done = 1'b1;
                cbr_want  = (owed_cnt != '0);
            end
            default:   cbr_want = 1'b0;
        endcase
    end

    assign host_ok = host_req && init_done;

    refseq_interval #(
        .INTERVAL_CYC(INTERVAL_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (run_phase),
        .tick   (tick)
    );

    refseq_owed #(
        .OWED_MAX(OWED_MAX)
    ) u_owed (
        .clk       (clk),
        .rst_n     (rst_n),
        .add       (tick),
        .take      (cbr_done && run_phase),
        .owed      (owed_cnt),
        .saturated (owed_sat)
    );

    refseq_cbr #(
        .T_RP (T_RP),
        .T_CSR(T_CSR),
        .T_RAS(T_RAS)
    ) u_cbr (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (cbr_want),
        .gnt   (refresh_gnt),
        .req   (refresh_req),
        .ras_n (ram_ras_n),
        .cas_n (ram_cas_n),
        .we_n  (ram_we_n),
        .done  (cbr_done)
    );

endmodule

// File: rtl/refseq_checker.sv
module refseq_checker #(
    parameter int OWED_MAX  = 8,
    parameter int T_RAS     = 6,
    parameter int PAUSE_CYC = 20000,
    parameter int OW        = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          refresh_req,
    input logic          ram_ras_n,
    input logic          ram_cas_n,
    input logic          init_done,
    input logic          host_ok,
    input logic          owed_sat,
    input logic [OW-1:0] owed
);
    int since_rst;
    int ras_lo_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst  <= 0;
            ras_lo_cnt <= 0;
        end else begin
            if (since_rst < PAUSE_CYC) since_rst <= since_rst + 1;
            ras_lo_cnt <= ram_ras_n ? 0 : ras_lo_cnt + 1;
        end
    end

    AST_NO_REQ_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < PAUSE_CYC) |-> !refresh_req); // R2

    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R3

    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_ras_n) |-> (!ram_cas_n && $past(!ram_cas_n))); // R4

    AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_ras_n) |-> (ras_lo_cnt == T_RAS)); // R4

    AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_cas_n |-> refresh_req); // R6

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_ras_n) |-> !refresh_req); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= OW'(OWED_MAX)); // R8

    AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        owed_sat |=> owed_sat); // R8

    AST_HOST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !host_ok); // R9

endmodule

bind dram_refresh_seq refseq_checker #(
    .OWED_MAX (OWED_MAX),
    .T_RAS    (T_RAS),
    .PAUSE_CYC(PAUSE_CYC),
    .OW       (OW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .refresh_req(refresh_req),
    .ram_ras_n  (ram_ras_n),
    .ram_cas_n  (ram_cas_n),
    .init_done  (init_done),
    .host_ok    (host_ok),
    .owed_sat   (owed_sat),
    .owed       (owed_cnt)
);

// File: tb/sim_dram_refresh_seq.sv
`timescale 1ns/1ps
module sim_dram_refresh_seq;
    localparam int PAUSE = 300;
    localparam int IVL   = 400;
    localparam int NINIT = 8;
    localparam int OMAX  = 8;
    localparam int TRP   = 4;
    localparam int TCSR  = 1;
    localparam int TRAS  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic refresh_gnt = 1'b0;
    logic host_req = 1'b1;
    logic refresh_req, ram_ras_n, ram_cas_n, ram_we_n, init_done, host_ok, owed_sat;

    always #5 clk = ~clk;

    dram_refresh_seq #(
        .PAUSE_CYC(PAUSE), .INTERVAL_CYC(IVL), .INIT_CYCLES(NINIT),
        .OWED_MAX(OMAX), .T_RP(TRP), .T_CSR(TCSR), .T_RAS(TRAS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .refresh_gnt(refresh_gnt), .host_req(host_req),
        .refresh_req(refresh_req), .ram_ras_n(ram_ras_n), .ram_cas_n(ram_cas_n),
        .ram_we_n(ram_we_n), .init_done(init_done), .host_ok(host_ok),
        .owed_sat(owed_sat)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit grant_en = 0;

    typedef struct { int lead; int low; } exp_t;
    exp_t q[$];
    int cbr_seen = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic push_cbr(input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.lead = TCSR;
            e.low  = TRAS;
            q.push_back(e);
        end
    endtask

    // access controller model: grant follows the request when enabled
    always @(negedge clk) refresh_gnt <= grant_en && refresh_req;

    // monitor
    int lead_c = 0, low_c = 0, prech_c = 1000;
    logic prev_ras = 1'b1, prev_cas = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_ras_n && !prev_ras) begin
                cbr_seen++;
                if (q.size() == 0) begin
                    chk(0, "R6 unexpected CBR cycle", cbr_seen, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(lead_c == e.lead, "R4 CAS lead", lead_c, e.lead);
                    chk(low_c == e.low, "R4 RAS low width", low_c, e.low);
                end
                chk(ram_cas_n == 1'b1, "R4 strobes rise together", ram_cas_n, 1);
                chk(refresh_req == 1'b0, "R6 request drops", refresh_req, 0);
                lead_c = 0;
                low_c  = 0;
            end
            if (!ram_ras_n || !ram_cas_n) begin
                if (refresh_gnt !== 1'b1) chk(0, "R6 strobe without grant", refresh_gnt, 1);
                if (refresh_req !== 1'b1) chk(0, "R6 request held", refresh_req, 1);
            end
            if (!ram_ras_n) begin
                low_c++;
                if (ram_we_n !== 1'b1) chk(0, "R5 WE high", ram_we_n, 1);
            end else if (!ram_cas_n) begin
                if (prev_cas) begin
                    chk(prech_c >= TRP, "R4 precharge", prech_c, TRP);
                    prech_c = 0;
                end
                lead_c++;
            end else begin
                prech_c++;
            end
            prev_ras = ram_ras_n;
            prev_cas = ram_cas_n;
        end
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int k;
        int base;
        repeat (3) @(negedge clk);
        chk(ram_ras_n == 1 && ram_cas_n == 1 && ram_we_n == 1, "R1 strobes high in reset",
            {ram_ras_n, ram_cas_n, ram_we_n}, 7);
        chk(refresh_req == 0 && init_done == 0, "R1 req/init low in reset",
            {refresh_req, init_done}, 0);
        chk(host_ok == 0 && owed_sat == 0, "R1 host_ok/owed_sat low in reset",
            {host_ok, owed_sat}, 0);

        push_cbr(NINIT);
        grant_en = 1;
        rst_n = 1'b1;

        // R2: pause length
        repeat (PAUSE - 1) @(negedge clk);
        chk(refresh_req == 0, "R2 no request before pause end", refresh_req, 0);
        chk(host_ok == 0, "R9 host blocked during init", host_ok, 0);
        @(negedge clk);
        chk(refresh_req == 1, "R2 request right after pause", refresh_req, 1);

        // R3: init cycles
        k = 0;
        while (!init_done && k < 2000) begin
            @(negedge clk);
            if (!init_done && host_ok) chk(0, "R9 host passed before init", host_ok, 0);
            k++;
        end
        grant_en = 0;
        chk(init_done == 1, "R3 init_done rises", init_done, 1);
        chk(cbr_seen == NINIT, "R3 init CBR count", cbr_seen, NINIT);
        chk(q.size() == 0, "R3 all init cycles consumed", q.size(), 0);
        chk(host_ok == 1, "R9 host passed after init", host_ok, 1);

        // R7: first owed request timing; k counts negedges since init_done seen
        k = 0;
        repeat (IVL - 1) begin @(negedge clk); k++; end
        chk(refresh_req == 0, "R7 no request before interval", refresh_req, 0);
        @(negedge clk); k++;
        chk(refresh_req == 1, "R7 request after one interval", refresh_req, 1);

        // R8: starvation
        while (k < 7 * IVL + 5) begin @(negedge clk); k++; end
        chk(owed_sat == 0, "R8 not saturated at seven owed", owed_sat, 0);
        chk(ram_ras_n == 1 && refresh_req == 1, "R6 waits for grant",
            {ram_ras_n, refresh_req}, 3);
        while (k < 12 * IVL + 5) begin @(negedge clk); k++; end
        chk(owed_sat == 1, "R8 saturation flag", owed_sat, 1);
        chk(init_done == 1, "R3 init_done stays high", init_done, 1);

        base = cbr_seen;
        push_cbr(OMAX);
        grant_en = 1;
        repeat (200) begin @(negedge clk); k++; end
        chk(cbr_seen - base == OMAX, "R8 served count after starvation", cbr_seen - base, OMAX);
        chk(refresh_req == 0, "R6 request low when nothing owed", refresh_req, 0);
        chk(owed_sat == 1, "R8 flag sticky", owed_sat, 1);

        // R7: next regular tick
        base = cbr_seen;
        push_cbr(1);
        while (k < 13 * IVL + 40) begin @(negedge clk); k++; end
        chk(cbr_seen - base == 1, "R7 one refresh per interval", cbr_seen - base, 1);
        chk(q.size() == 0, "R7 scoreboard empty", q.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule